// File: doc/BRIEF.md
# Background-Calibrating Conversion Sequencer

This block paces the conversion slots of a sigma-delta decimation path and keeps its calibration coefficients up to date while conversions continue. A filter code sets the slot length, so it also sets the output word rate. A mode input selects one of three behaviours: halted, plain conversion, or conversion with background calibration. A sync input restarts the slot timing cleanly. The modulator and the digital filter are outside the block. They appear only as a raw result bus, which is sampled on the last cycle of every slot. A source-kind output tells that result source which input to present during each slot.

With background calibration on, every six slots form a cycle. Four slots measure the signal. One slot measures the shorted input and refreshes the offset coefficient. One slot measures the reference input and refreshes the gain coefficient through a sequential divider. The four signal measurements are averaged into a single output word, so one word appears per six slots. Every output word is offset- and gain-corrected and clamped to the unsigned code range. Both coefficients can also be read out and overwritten at any time.

Top module: `bgcal_sequencer`

## Requirements
- R1: `code_err_o` is high exactly when `filt_code_i` is below 19 or above 2000. While it is high, `slot_done_o` never pulses and the slot timing is held at its start.
- R2: With a valid code and an active mode, `slot_done_o` pulses for one cycle every `filt_code_i * CYC_PER_CODE` cycles.
- R3: In normal mode (`mode_i` = 2'b01), every slot is a signal slot. `result_valid_o` pulses in the cycle after each `slot_done_o`, and `result_o` then holds the corrected value of the raw word sampled in the `slot_done_o` cycle.
- R4: In background mode (`mode_i` = 2'b10), slots repeat in a six-slot order: four signal slots (`src_kind_o` = 2'b00), then one zero slot (2'b01), then one reference slot (2'b10). `result_valid_o` pulses only after the fourth signal slot of each cycle.
- R5: In background mode, the output word is the corrected value of the floor of the mean of the four signal raw words in that cycle.
- R6: The raw word of a zero slot becomes `offset_o` in the next cycle.
- R7: After a reference slot, with span = raw − offset, `gain_o` becomes floor(2^47 / span) within 28 cycles. If span is at most 2^23 (or negative), `gain_o` becomes all ones.
- R8: The correction is (raw − offset) × gain / 2^23, rounded toward minus infinity, with gain an unsigned 1.23 value. A negative result outputs all zeros, and a result above 2^24 − 1 outputs all ones.
- R9: A cycle with `coef_wr_i` high replaces the offset (`coef_sel_i` = 0) or the gain (`coef_sel_i` = 1) with `coef_wdata_i`, visible on `offset_o` / `gain_o` in the next cycle. Reset values are offset 0 and gain 2^23.
- R10: A `sync_i` cycle restarts the slot timing and the six-slot order. The next `slot_done_o` comes a full slot length after `sync_i` is taken.
- R11: With `mode_i` at 2'b00 or 2'b11, no slot completes and no result is produced.
- R12: `chan_o` captures `chan_i` only when a slot starts (after `slot_done_o`, on `sync_i`, or while not running), so it never changes in the middle of a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (modulator clock domain) |
| rst_n | input | 1 | Asynchronous active-low reset |
| filt_code_i | input | CODE_W | Filter code, slot length in code units |
| mode_i | input | 2 | 01 normal, 10 background calibration, other halted |
| chan_i | input | CH_W | Requested input channel |
| sync_i | input | 1 | Restart slot timing |
| raw_i | input | DATA_W | Raw filtered result, sampled in the slot_done_o cycle |
| coef_wr_i | input | 1 | Coefficient write strobe |
| coef_sel_i | input | 1 | 0 offset, 1 gain |
| coef_wdata_i | input | DATA_W | Coefficient write value |
| code_err_o | output | 1 | Filter code out of range |
| slot_done_o | output | 1 | Last cycle of a slot |
| src_kind_o | output | 2 | Input to present: 00 signal, 01 zero, 10 reference |
| chan_o | output | CH_W | Channel held for the current slot |
| result_o | output | DATA_W | Corrected, clamped output word |
| result_valid_o | output | 1 | One-cycle pulse with a new result_o |
| offset_o | output | DATA_W | Offset coefficient |
| gain_o | output | DATA_W | Gain coefficient, unsigned 1.23 |

## Verification
A result is due exactly one cycle after the `slot_done_o` cycle that sampled it. The offset refresh and coefficient writes also show up one cycle later. A gain refresh settles within 28 cycles of its reference slot, which is well inside the next slot. After a sync, the first slot end lands a whole slot length later, and later slot ends follow at that same spacing. The bench drives inputs and samples outputs on the falling edge. It counts falling edges from each stimulus and checks each value at the exact count derived from these latencies. The only exception is the gain, which it checks at a point past the 28-cycle bound but before the next slot can end.

// File: rtl/bgcal_pkg.sv
package bgcal_pkg;

   typedef enum logic [1:0] {
      SRC_SIGNAL = 2'b00,
      SRC_ZERO   = 2'b01,
      SRC_REF    = 2'b10
   } src_kind_e;

   localparam logic [1:0] MODE_NORMAL = 2'b01;
   localparam logic [1:0] MODE_BGCAL  = 2'b10;

   // six-slot background cycle: signal slots first, then zero, then reference
   localparam int SIG_SLOTS   = 4;
   localparam int CYCLE_SLOTS = SIG_SLOTS + 2;

endpackage

// File: rtl/bgcal_slot_timer.sv
module bgcal_slot_timer #(
   parameter int CNT_W = 12,
   parameter int IDX_W = 3,
   parameter int LAST_IDX = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             sync,
   input  logic             bg,
   input  logic [CNT_W-1:0] len,
   output logic             done,
   output logic [IDX_W-1:0] idx
);

   logic [CNT_W-1:0] cnt;

   assign done = run && !sync && (cnt == len - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         idx <= '0;
      end else if (sync || !run) begin
         cnt <= '0;
         idx <= '0;
      end else if (done) begin
         cnt <= '0;
         if (bg && (idx != IDX_W'(LAST_IDX)))
            idx <= idx + IDX_W'(1);
         else
            idx <= '0;
      end else begin
         cnt <= cnt + CNT_W'(1);
      end
   end

endmodule

// File: rtl/bgcal_gain_div.sv
module bgcal_gain_div #(
   parameter int W    = 24,
   parameter int FRAC = 23
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic signed [W:0] span,
   output logic              done,
   output logic [W-1:0]      quot
);

   localparam int STEP_W = $clog2(W + 1);
   localparam logic signed [W:0] SPAN_MIN = {{(W-FRAC){1'b0}}, 1'b1, {FRAC{1'b0}}};

   logic              busy;
   logic [STEP_W-1:0] step;
   logic [W:0]        rem;
   logic [W:0]        dv;
   logic [W+1:0]      rem2;

   assign rem2 = {rem, 1'b0};

   // restoring division of 2^(W+FRAC) by span, one quotient bit per cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         step <= '0;
         rem  <= '0;
         dv   <= '0;
         quot <= '0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            busy <= 1'b1;
            dv   <= span;
            if (span <= SPAN_MIN) begin
               quot <= '1;
               rem  <= '0;
               step <= '0;
            end else begin
               quot <= '0;
               rem  <= SPAN_MIN;
               step <= STEP_W'(W);
            end
         end else if (busy) begin
            if (step == '0) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               if (rem2 >= {1'b0, dv}) begin
                  rem  <= (W+1)'(rem2 - {1'b0, dv});
                  quot <= {quot[W-2:0], 1'b1};
               end else begin
                  rem  <= (W+1)'(rem2);
                  quot <= {quot[W-2:0], 1'b0};
               end
               step <= step - STEP_W'(1);
            end
         end
      end
   end

endmodule

// File: rtl/bgcal_correct.sv
module bgcal_correct #(
   parameter int W    = 24,
   parameter int FRAC = 23
) (
   input  logic [W-1:0] raw,
   input  logic [W-1:0] offset,
   input  logic [W-1:0] gain,
   output logic [W-1:0] value
);

   logic signed [W:0]     diff;
   logic signed [2*W+1:0] diff_x;
   logic signed [2*W+1:0] gain_x;
   logic signed [2*W+1:0] prod;
   logic signed [2*W+1:0] scaled;

   assign diff   = $signed({1'b0, raw}) - $signed({1'b0, offset});
   assign diff_x = {{(W+1){diff[W]}}, diff};
   assign gain_x = $signed({{(W+2){1'b0}}, gain});
   assign prod   = diff_x * gain_x;
   assign scaled = prod >>> FRAC;

   always_comb begin
      if (scaled[2*W+1])
         value = '0;
      else if (scaled[2*W+1:W] != '0)
         value = '1;
      else
         value = scaled[W-1:0];
   end

endmodule

// File: rtl/bgcal_sequencer.sv
module bgcal_sequencer
   import bgcal_pkg::*;
#(
   parameter int DATA_W       = 24,
   parameter int GAIN_FRAC    = 23,
   parameter int CODE_W       = 11,
   parameter int CODE_MIN     = 19,
   parameter int CODE_MAX     = 2000,
   parameter int CYC_PER_CODE = 2,
   parameter int CH_W         = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] filt_code_i,
   input  logic [1:0]        mode_i,
   input  logic [CH_W-1:0]   chan_i,
   input  logic              sync_i,
   input  logic [DATA_W-1:0] raw_i,
   input  logic              coef_wr_i,
   input  logic              coef_sel_i,
   input  logic [DATA_W-1:0] coef_wdata_i,
   output logic              code_err_o,
   output logic              slot_done_o,
   output logic [1:0]        src_kind_o,
   output logic [CH_W-1:0]   chan_o,
   output logic [DATA_W-1:0] result_o,
   output logic              result_valid_o,
   output logic [DATA_W-1:0] offset_o,
   output logic [DATA_W-1:0] gain_o
);

   localparam int CNT_W    = $clog2(CODE_MAX * CYC_PER_CODE + 1);
   localparam int IDX_W    = $clog2(CYCLE_SLOTS);
   localparam int AVG_SH   = $clog2(SIG_SLOTS);
   localparam int ACC_W    = DATA_W + AVG_SH;
   localparam logic [DATA_W-1:0] GAIN_ONE =
      {{(DATA_W-GAIN_FRAC-1){1'b0}}, 1'b1, {GAIN_FRAC{1'b0}}};

   if (GAIN_FRAC >= DATA_W) begin : g_bad_frac
      $error("GAIN_FRAC must be below DATA_W");
   end
   if (CODE_MAX >= (1 << CODE_W) || CODE_MIN < 1 || CODE_MIN > CODE_MAX) begin : g_bad_code
      $error("code limits do not fit CODE_W");
   end
   if (CODE_MIN * CYC_PER_CODE <= DATA_W + 3) begin : g_bad_slot
      $error("shortest slot must outlast the gain divider");
   end

   logic              code_bad;
   logic              bg;
   logic              run;
   logic              slot_done;
   logic [IDX_W-1:0]  slot_idx;
   logic [CNT_W-1:0]  slot_len;
   src_kind_e         kind;
   logic [ACC_W-1:0]  acc;
   logic [ACC_W-1:0]  sum;
   logic              emit;
   logic [DATA_W-1:0] out_raw;
   logic [DATA_W-1:0] corr_val;
   logic              div_start;
   logic              div_done;
   logic [DATA_W-1:0] div_q;
   logic signed [DATA_W:0] span;

   assign code_bad = (filt_code_i < CODE_W'(CODE_MIN)) || (filt_code_i > CODE_W'(CODE_MAX));
   assign bg       = (mode_i == MODE_BGCAL);
   assign run      = !code_bad && (bg || mode_i == MODE_NORMAL);
   assign slot_len = CNT_W'(filt_code_i) * CNT_W'(CYC_PER_CODE);

   bgcal_slot_timer #(
      .CNT_W   (CNT_W),
      .IDX_W   (IDX_W),
      .LAST_IDX(CYCLE_SLOTS - 1)
   ) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .sync (sync_i),
      .bg   (bg),
      .len  (slot_len),
      .done (slot_done),
      .idx  (slot_idx)
   );

   always_comb begin
      if (!bg)
         kind = SRC_SIGNAL;
      else if (slot_idx == IDX_W'(SIG_SLOTS))
         kind = SRC_ZERO;
      else if (slot_idx == IDX_W'(SIG_SLOTS + 1))
         kind = SRC_REF;
      else
         kind = SRC_SIGNAL;
   end

   assign sum  = acc + ACC_W'(raw_i);
   assign emit = slot_done && (kind == SRC_SIGNAL) &&
                 (!bg || slot_idx == IDX_W'(SIG_SLOTS - 1));
   assign out_raw = bg ? DATA_W'(sum >> AVG_SH) : raw_i;

   bgcal_correct #(
      .W   (DATA_W),
      .FRAC(GAIN_FRAC)
   ) u_correct (
      .raw   (out_raw),
      .offset(offset_o),
      .gain  (gain_o),
      .value (corr_val)
   );

   assign div_start = slot_done && (kind == SRC_REF);
   assign span      = $signed({1'b0, raw_i}) - $signed({1'b0, offset_o});

   bgcal_gain_div #(
      .W   (DATA_W),
      .FRAC(GAIN_FRAC)
   ) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .start(div_start),
      .span (span),
      .done (div_done),
      .quot (div_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc            <= '0;
         result_o       <= '0;
         result_valid_o <= 1'b0;
         chan_o         <= '0;
         offset_o       <= '0;
         gain_o         <= GAIN_ONE;
      end else begin
         result_valid_o <= emit;
         if (emit)
            result_o <= corr_val;

         if (sync_i || !run || emit)
            acc <= '0;
         else if (slot_done && kind == SRC_SIGNAL)
            acc <= sum;

         if (sync_i || !run || slot_done)
            chan_o <= chan_i;

         if (coef_wr_i && !coef_sel_i)
            offset_o <= coef_wdata_i;
         else if (slot_done && kind == SRC_ZERO)
            offset_o <= raw_i;

         if (coef_wr_i && coef_sel_i)
            gain_o <= coef_wdata_i;
         else if (div_done)
            gain_o <= div_q;
      end
   end

   assign code_err_o  = code_bad;
   assign slot_done_o = slot_done;
   assign src_kind_o  = kind;

endmodule

// File: rtl/bgcal_sequencer_chk.sv
module bgcal_sequencer_chk
   import bgcal_pkg::*;
#(
   parameter int DATA_W = 24,
   parameter int IDX_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sync_i,
   input logic              code_err_o,
   input logic              slot_done_o,
   input logic [1:0]        src_kind_o,
   input logic [IDX_W-1:0]  slot_idx,
   input logic              result_valid_o,
   input logic              coef_wr_i,
   input logic              coef_sel_i,
   input logic [DATA_W-1:0] offset_o
);

   a_r1_no_slot_on_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
      code_err_o |-> !slot_done_o);

   a_r10_sync_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      sync_i |=> !slot_done_o);

   a_r3_valid_after_signal_slot: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid_o |-> ($past(slot_done_o) && $past(src_kind_o) == SRC_SIGNAL));

   a_r4_cal_slot_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_done_o && src_kind_o != SRC_SIGNAL) |=> !result_valid_o);

   a_r4_slot_index_range: assert property (@(posedge clk) disable iff (!rst_n)
      slot_idx < IDX_W'(CYCLE_SLOTS));

   a_r6_offset_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!(coef_wr_i && !coef_sel_i) && !(slot_done_o && src_kind_o == SRC_ZERO))
      |=> $stable(offset_o));

endmodule

bind bgcal_sequencer bgcal_sequencer_chk #(
   .DATA_W(DATA_W),
   .IDX_W (IDX_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .sync_i        (sync_i),
   .code_err_o    (code_err_o),
   .slot_done_o   (slot_done_o),
   .src_kind_o    (src_kind_o),
   .slot_idx      (slot_idx),
   .result_valid_o(result_valid_o),
   .coef_wr_i     (coef_wr_i),
   .coef_sel_i    (coef_sel_i),
   .offset_o      (offset_o)
);

// File: tb/bgcal_sequencer_test.sv
module bgcal_sequencer_test;

   localparam int CLK_PERIOD = 10;
   localparam int DW   = 24;
   localparam int CPC  = 2;
   localparam int CODE = 20;
   localparam int LEN  = CODE * CPC;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [10:0]   filt_code_i = 11'd0;
   logic [1:0]    mode_i = 2'b00;
   logic [1:0]    chan_i = 2'd0;
   logic          sync_i = 1'b0;
   logic [DW-1:0] raw_i;
   logic          coef_wr_i = 1'b0;
   logic          coef_sel_i = 1'b0;
   logic [DW-1:0] coef_wdata_i = '0;
   logic          code_err_o;
   logic          slot_done_o;
   logic [1:0]    src_kind_o;
   logic [1:0]    chan_o;
   logic [DW-1:0] result_o;
   logic          result_valid_o;
   logic [DW-1:0] offset_o;
   logic [DW-1:0] gain_o;

   logic [DW-1:0] sig_v = '0;
   logic [DW-1:0] zero_v = '0;
   logic [DW-1:0] ref_v = '0;
   logic [DW-1:0] e_off;
   logic [DW-1:0] e_gain;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   // result source model: presents the input the sequencer asks for
   always_comb begin
      case (src_kind_o)
         2'b01:   raw_i = zero_v;
         2'b10:   raw_i = ref_v;
         default: raw_i = sig_v;
      endcase
   end

   bgcal_sequencer #(.CYC_PER_CODE(CPC)) uut (
      .clk(clk), .rst_n(rst_n), .filt_code_i(filt_code_i), .mode_i(mode_i),
      .chan_i(chan_i), .sync_i(sync_i), .raw_i(raw_i), .coef_wr_i(coef_wr_i),
      .coef_sel_i(coef_sel_i), .coef_wdata_i(coef_wdata_i),
      .code_err_o(code_err_o), .slot_done_o(slot_done_o), .src_kind_o(src_kind_o),
      .chan_o(chan_o), .result_o(result_o), .result_valid_o(result_valid_o),
      .offset_o(offset_o), .gain_o(gain_o)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] f_corr(input logic [DW-1:0] raw,
                                            input logic [DW-1:0] off,
                                            input logic [DW-1:0] g);
      longint d = longint'(raw) - longint'(off);
      longint p = (d * longint'(g)) >>> 23;
      if (p < 0) return '0;
      if (p > 64'hFFFFFF) return '1;
      return p[DW-1:0];
   endfunction

   function automatic logic [DW-1:0] f_gain(input logic [DW-1:0] r, input logic [DW-1:0] z);
      longint span = longint'(r) - longint'(z);
      if (span <= (64'd1 << 23)) return '1;
      return DW'((64'd1 << 47) / span);
   endfunction

   task automatic wait_done();
      do @(negedge clk); while (!slot_done_o);
   endtask

   task automatic pulse_sync();
      @(negedge clk) sync_i = 1'b1;
      @(negedge clk) sync_i = 1'b0;
   endtask

   // falling edges from the current one (counted as 1) until slot_done_o
   task automatic count_to_done(output int n);
      n = 1;
      while (!slot_done_o) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic wr_coef(input logic sel, input logic [DW-1:0] val);
      @(negedge clk);
      coef_wr_i = 1'b1; coef_sel_i = sel; coef_wdata_i = val;
      @(negedge clk);
      coef_wr_i = 1'b0;
      if (sel) begin
         e_gain = val;
         chk("R9 gain write", gain_o, val);
      end else begin
         e_off = val;
         chk("R9 offset write", offset_o, val);
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R9 reset offset", offset_o, 0);
      chk("R9 reset gain", gain_o, 24'h800000);
      chk("R11 reset no valid", result_valid_o, 0);
      chk("R11 reset no slot", slot_done_o, 0);
      e_off = '0; e_gain = 24'h800000;
   endtask

   task automatic t_code_range();
      int n;
      int seen = 0;
      mode_i = 2'b01;
      filt_code_i = 11'd18;
      @(negedge clk);
      chk("R1 code 18 flagged", code_err_o, 1);
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (slot_done_o) seen++;
      end
      chk("R1 no slots on code 18", seen, 0);
      filt_code_i = 11'd2001;
      @(negedge clk);
      chk("R1 code 2001 flagged", code_err_o, 1);
      filt_code_i = 11'd2000;
      @(negedge clk);
      chk("R1 code 2000 accepted", code_err_o, 0);
      filt_code_i = 11'd19;
      pulse_sync();
      chk("R1 code 19 accepted", code_err_o, 0);
      count_to_done(n);
      chk("R2 slot length at code 19", n, 19 * CPC);
   endtask

   task automatic t_slot_len();
      int n;
      filt_code_i = CODE;
      pulse_sync();
      count_to_done(n);
      chk("R10 first slot after sync", n, LEN);
      n = 0;
      do begin @(negedge clk); n++; end while (!slot_done_o);
      chk("R2 slot spacing", n, LEN);
   endtask

   task automatic t_normal();
      logic [DW-1:0] vals [4] = '{24'd1000, 24'd50, 24'd4100, 24'hF00000};
      logic [DW-1:0] gains [4] = '{24'h800000, 24'h800000, 24'h600000, 24'hFFFFFF};
      mode_i = 2'b01;
      wr_coef(1'b0, 24'd100);
      for (int i = 0; i < 4; i++) begin
         wr_coef(1'b1, gains[i]);
         sig_v = vals[i];
         wait_done();
         chk("R3 signal kind in normal", src_kind_o, 2'b00);
         @(negedge clk);
         chk("R3 valid after slot", result_valid_o, 1);
         chk("R8 corrected value", result_o, f_corr(vals[i], e_off, e_gain));
         @(negedge clk);
         chk("R3 valid is one cycle", result_valid_o, 0);
      end
   endtask

   task automatic t_background();
      logic [DW+1:0] sum;
      mode_i = 2'b10;
      zero_v = 24'h010000;
      pulse_sync();
      for (int c = 0; c < 3; c++) begin
         ref_v = (c == 2) ? zero_v + 24'd1000 : 24'hE10000 + DW'(c * 24'h1000);
         sum = '0;
         for (int s = 0; s < 4; s++) begin
            sig_v = 24'h300000 + DW'(s * 24'h011111) + DW'(c * 24'h000333);
            sum += (DW+2)'(sig_v);
            wait_done();
            chk("R4 signal slot kind", src_kind_o, 2'b00);
            @(negedge clk);
            if (s < 3) begin
               chk("R4 no word mid cycle", result_valid_o, 0);
            end else begin
               chk("R4 one word per cycle", result_valid_o, 1);
               chk("R5 averaged corrected word", result_o,
                   f_corr(DW'(sum >> 2), e_off, e_gain));
            end
         end
         wait_done();
         chk("R4 zero slot kind", src_kind_o, 2'b01);
         @(negedge clk);
         e_off = zero_v;
         chk("R6 offset refreshed", offset_o, zero_v);
         chk("R4 zero slot silent", result_valid_o, 0);
         wait_done();
         chk("R4 reference slot kind", src_kind_o, 2'b10);
         @(negedge clk);
         chk("R4 reference slot silent", result_valid_o, 0);
         e_gain = f_gain(ref_v, e_off);
         repeat (DW + 4) @(negedge clk);
         chk("R7 gain refreshed", gain_o, e_gain);
      end
   endtask

   task automatic t_sync_mid();
      int n;
      mode_i = 2'b01;
      repeat (11) @(negedge clk);
      pulse_sync();
      count_to_done(n);
      chk("R10 restart after mid-slot sync", n, LEN);
   endtask

   task automatic t_chan();
      wait_done();
      chan_i = 2'd1;
      @(negedge clk);
      chan_i = 2'd3;
      @(negedge clk);
      chk("R12 channel held mid slot", chan_o, 2'd1);
      wait_done();
      @(negedge clk);
      chk("R12 channel taken at slot start", chan_o, 2'd3);
   endtask

   task automatic t_halt();
      int seen = 0;
      mode_i = 2'b00;
      for (int i = 0; i < 120; i++) begin
         @(negedge clk);
         if (slot_done_o || result_valid_o) seen++;
      end
      mode_i = 2'b11;
      for (int i = 0; i < 120; i++) begin
         @(negedge clk);
         if (slot_done_o || result_valid_o) seen++;
      end
      chk("R11 halted modes idle", seen, 0);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_code_range();
      t_slot_len();
      t_normal();
      t_background();
      t_sync_mid();
      t_chan();
      t_halt();
      finish_run();
   end

endmodule